// File: doc/BRIEF.md
# Page Write Buffer and Sequencer

This block sits behind the serial front end of a small nonvolatile memory. When a write transaction is opened, it takes the start address and then gathers the incoming data bytes into a page-sized staging buffer. Each buffered byte has a valid flag. Successive bytes land at successive offsets inside one page. When the offset runs past the end of the page it returns to the first location of that same page. A byte that lands on an offset already filled replaces the earlier byte.

Nothing reaches the array while loading. When chip select is released after one or more whole bytes, the sequencer scans every buffer offset in ascending order, taking one clock per offset. It issues one array write strobe for each offset whose valid flag is set. It then holds a busy flag for a counted programming interval. When that interval ends, it pulses a request that tells the front end to clear its write-enable latch. A release in the middle of a byte, or a release with no data byte at all, throws the transaction away.

Top module: `page_write_seq`

## Requirements
- R1: After reset `busy`, `mem_we` and `wel_clear` are all low.
- R2: A transaction is opened only by `start_valid` while idle with `wel_set` high and `prot_hit` low. If `wel_set` is low or `prot_hit` is high, that transaction produces no write strobe, no busy period and no `wel_clear`.
- R3: The k-th data byte (k counted from 0) is stored at page offset (start offset + k) mod PAGE_BYTES. The page offset is the low log2(PAGE_BYTES) address bits. The page number is the upper address bits, and it stays that of `start_addr` for every byte.
- R4: When more bytes than PAGE_BYTES are loaded, a byte that lands on an offset already holding data replaces it. Each offset is written to the array at most once, with the last byte loaded there.
- R5: No write strobe and no busy occur while bytes are being loaded, before `cs_rise`.
- R6: If `cs_rise` arrives with `byte_partial` high, or before any data byte, the buffer is discarded. No write strobe, busy period or `wel_clear` follows.
- R7: On a valid `cs_rise`, the write strobes come from offsets with a stored byte only. They are issued in ascending offset order, one per clock, with `mem_addr` inside the transaction's page.
- R8: `busy` rises in the cycle after a valid `cs_rise` and stays high for exactly PAGE_BYTES + BUSY_CYCLES clocks: the commit scan plus the programming interval.
- R9: `wel_clear` is a single-cycle pulse in the first cycle in which `busy` is low again after a commit.
- R10: While `busy` is high, `start_valid`, `byte_valid` and `cs_rise` have no effect on the array writes or on the length of the busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Opens a write transaction with `start_addr` |
| start_addr | input | ADDR_W | First byte address of the transaction |
| wel_set | input | 1 | Write-enable latch state from the front end |
| prot_hit | input | 1 | High when the target lies in a protected region |
| byte_valid | input | 1 | One-cycle strobe: a complete data byte is on `byte_data` |
| byte_data | input | 8 | Received data byte |
| cs_rise | input | 1 | One-cycle event: chip select was released |
| byte_partial | input | 1 | Qualifies `cs_rise`: bits of an unfinished byte were pending |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Commit scan or programming interval in progress |
| wel_clear | output | 1 | One-cycle request to clear the write-enable latch |

## Verification
The bench builds the block with ADDR_W = 6 (four pages), PAGE_BYTES = 16 and BUSY_CYCLES = 12, so each commit and programming interval lasts only 28 clocks. That makes it affordable to sweep every start offset against every byte count from 1 to 20. The sweep covers partial pages, a page that ends exactly at the boundary, and every wrap with overwrite. The small interval also allows traffic to be injected during busy, and it makes room for the denied, partial-byte and empty aborts.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_COMMIT = 2'd2,
    ST_BUSY   = 2'd3
  } pwb_state_t;
endpackage

// File: rtl/pwb_buffer.sv
module pwb_buffer #(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  output logic [DEPTH-1:0] valid_mask
);
  // data store: no reset, registered read, so it maps onto block RAM
  logic [7:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) ram[wr_idx] <= wr_data;
    rd_data <= ram[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) valid_mask <= '0;
    else if (wr_en) valid_mask[wr_idx] <= 1'b1;
  end

  // a loaded byte always leaves its offset marked
  assert_mask_marks_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clr) |=> valid_mask[$past(wr_idx)]);
  // a cleared buffer holds nothing
  assert_mask_cleared_R6: assert property (@(posedge clk) disable iff (rst)
    (clr && !wr_en) |=> (valid_mask == '0));
endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
  parameter int CYCLES = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic expired
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;

  assign expired = run_q && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (arm) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (expired) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_count_range_R8: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt_q <= LAST));
  assert_stop_on_expiry_R8: assert property (@(posedge clk) disable iff (rst)
    (expired && !arm) |=> !run_q);
endmodule

// File: rtl/page_write_seq.sv
module page_write_seq
  import pwb_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_valid,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              wel_set,
  input  logic              prot_hit,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              cs_rise,
  input  logic              byte_partial,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              busy,
  output logic              wel_clear
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(PAGE_BYTES - 1);

  pwb_state_t        state_q, state_d;
  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  load_off_q;
  logic [OFF_W-1:0]  scan_q;
  logic              got_q;
  logic [PAGE_BYTES-1:0] mask;
  logic              accept, buf_wr, got_now, scan_end, timer_done;

  assign accept   = (state_q == ST_IDLE) && start_valid && wel_set && !prot_hit;
  assign buf_wr   = (state_q == ST_LOAD) && byte_valid;
  assign got_now  = got_q || byte_valid;
  assign scan_end = (state_q == ST_COMMIT) && (scan_q == LAST_OFF);

  pwb_buffer #(.DEPTH(PAGE_BYTES), .IDX_W(OFF_W)) u_buf (
    .clk(clk), .rst(rst), .clr(accept),
    .wr_en(buf_wr), .wr_idx(load_off_q), .wr_data(byte_data),
    .rd_idx(scan_q), .rd_data(mem_wdata), .valid_mask(mask)
  );

  pwb_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .arm(scan_end), .expired(timer_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = ST_LOAD;
      ST_LOAD:   if (cs_rise) state_d = (got_now && !byte_partial) ? ST_COMMIT : ST_IDLE;
      ST_COMMIT: if (scan_end) state_d = ST_BUSY;
      ST_BUSY:   if (timer_done) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      page_q     <= '0;
      load_off_q <= '0;
      scan_q     <= '0;
      got_q      <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      busy       <= 1'b0;
      wel_clear  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        page_q     <= start_addr[ADDR_W-1:OFF_W];
        load_off_q <= start_addr[OFF_W-1:0];
        got_q      <= 1'b0;
        scan_q     <= '0;
      end
      if (buf_wr) begin
        load_off_q <= load_off_q + 1'b1;  // wraps inside the page
        got_q      <= 1'b1;
      end
      if (state_q == ST_COMMIT) scan_q <= scan_q + 1'b1;
      mem_we    <= (state_q == ST_COMMIT) && mask[scan_q];
      mem_addr  <= {page_q, scan_q};
      busy      <= (state_d == ST_COMMIT) || (state_d == ST_BUSY);
      wel_clear <= (state_q == ST_BUSY) && timer_done;
    end
  end

  assert_no_strobe_loading_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOAD) |-> !mem_we);
  assert_strobe_in_page_R3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[ADDR_W-1:OFF_W] == page_q));
  assert_strobe_under_busy_R7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);
  assert_strobe_ascending_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr[OFF_W-1:0] > $past(mem_addr[OFF_W-1:0])));
  assert_clear_after_busy_R9: assert property (@(posedge clk) disable iff (rst)
    wel_clear |-> (!busy && $past(busy)));
  assert_clear_single_R9: assert property (@(posedge clk) disable iff (rst)
    wel_clear |=> !wel_clear);
  assert_busy_blocks_open_R10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BUSY) |=> (state_q != ST_LOAD));
endmodule

// File: tb/page_write_seq_bench.sv
module page_write_seq_bench;
  localparam int AW = 6, PB = 16, BC = 12, NA = 64;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, start_valid = 0, wel_set = 0, prot_hit = 0;
  logic byte_valid = 0, cs_rise = 0, byte_partial = 0;
  logic [AW-1:0] start_addr = '0;
  logic [7:0] byte_data = '0;
  logic mem_we, busy, wel_clear;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;

  page_write_seq #(.ADDR_W(AW), .PAGE_BYTES(PB), .BUSY_CYCLES(BC)) u_page_write_seq (
    .clk(clk), .rst(rst), .start_valid(start_valid), .start_addr(start_addr),
    .wel_set(wel_set), .prot_hit(prot_hit), .byte_valid(byte_valid),
    .byte_data(byte_data), .cs_rise(cs_rise), .byte_partial(byte_partial),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .wel_clear(wel_clear)
  );

  int checks = 0, fails = 0;
  int hit [NA];
  logic [7:0] got [NA];
  int busy_cnt = 0, wclr_cnt = 0, strobe_cnt = 0, order_bad = 0, prev_addr = 0;
  logic prev_we = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_we) begin
        hit[mem_addr] = hit[mem_addr] + 1;
        got[mem_addr] = mem_wdata;
        strobe_cnt = strobe_cnt + 1;
        if (prev_we && int'(mem_addr) <= prev_addr) order_bad = order_bad + 1;
      end
      prev_we = mem_we;
      prev_addr = int'(mem_addr);
      if (busy) busy_cnt = busy_cnt + 1;
      if (wel_clear) wclr_cnt = wclr_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] dat(input int addr, input int n, input int k);
    return 8'((addr * 29 + n * 7 + k * 53 + 5) & 255);
  endfunction

  task automatic clr_log();
    for (int a = 0; a < NA; a++) hit[a] = 0;
    busy_cnt = 0; wclr_cnt = 0; strobe_cnt = 0; order_bad = 0;
  endtask

  task automatic run_case(input int addr, input int n, input bit partial,
                          input bit wel, input bit prot, input bit inject, input string req);
    bit commit;
    int page, off, mis, dmis, distinct;
    logic [7:0] exp_d [PB];
    bit exp_s [PB];
    clr_log();
    @(posedge clk); #1;
    start_valid = 1; start_addr = AW'(addr); wel_set = wel; prot_hit = prot;
    @(posedge clk); #1;
    start_valid = 0;
    for (int k = 0; k < n; k++) begin
      byte_valid = 1; byte_data = dat(addr, n, k);
      @(posedge clk); #1;
      byte_valid = 0;
    end
    @(negedge clk);
    chk(strobe_cnt == 0 && busy_cnt == 0, "R5", "activity before release", strobe_cnt + busy_cnt, 0);
    @(posedge clk); #1;
    cs_rise = 1; byte_partial = partial;
    @(posedge clk); #1;
    cs_rise = 0; byte_partial = 0; wel_set = 0; prot_hit = 0;
    if (inject) begin
      // R10: a complete transaction fired while busy must be ignored
      repeat (4) @(posedge clk); #1;
      start_valid = 1; start_addr = AW'(addr ^ 32); wel_set = 1;
      @(posedge clk); #1;
      start_valid = 0;
      byte_valid = 1; byte_data = 8'hEE;
      @(posedge clk); @(posedge clk); #1;
      byte_valid = 0; cs_rise = 1;
      @(posedge clk); #1;
      cs_rise = 0; wel_set = 0;
    end
    repeat (PB + BC + 6) @(posedge clk);
    @(negedge clk); #1;

    commit = wel && !prot && !partial && (n > 0);
    page = addr / PB;
    for (int i = 0; i < PB; i++) begin exp_s[i] = 0; exp_d[i] = '0; end
    for (int k = 0; k < n; k++) begin
      off = (addr % PB + k) % PB;
      exp_s[off] = 1; exp_d[off] = dat(addr, n, k);
    end
    mis = 0; dmis = 0; distinct = 0;
    for (int a = 0; a < NA; a++) begin
      int e;
      e = (commit && (a / PB) == page && exp_s[a % PB]) ? 1 : 0;
      distinct += e;
      if (hit[a] != e) mis++;
      else if (e == 1 && got[a] != exp_d[a % PB]) dmis++;
    end
    chk(mis == 0, req, "addresses with wrong strobe count (R3 R4 R7)", mis, 0);
    chk(dmis == 0, req, "addresses with wrong data (R3 R4)", dmis, 0);
    chk(strobe_cnt == distinct, req, "strobes (R7)", strobe_cnt, distinct);
    chk(order_bad == 0, req, "out-of-order strobes (R7)", order_bad, 0);
    chk(busy_cnt == (commit ? PB + BC : 0), req, "busy cycles (R8)", busy_cnt, commit ? PB + BC : 0);
    chk(wclr_cnt == (commit ? 1 : 0), req, "wel_clear pulses (R9)", wclr_cnt, commit ? 1 : 0);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(!busy && !mem_we && !wel_clear, "R1", "outputs after reset",
        int'(busy) + int'(mem_we) + int'(wel_clear), 0);

    for (int o = 0; o < PB; o++)
      for (int n = 1; n <= 20; n++)
        run_case(((o + n) % 4) * PB + o, n, 0, 1, 0, n == 2, (n == 2) ? "R10" : "R3");

    run_case(5, 4, 0, 0, 0, 0, "R2");
    run_case(37, 4, 0, 1, 1, 0, "R2");
    run_case(10, 3, 1, 1, 0, 0, "R6");
    run_case(20, 0, 0, 1, 0, 0, "R6");
    run_case(10, 1, 0, 1, 0, 0, "R6");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule